// File: doc/BRIEF.md
# Conditional Relative Branch Sequencer

This block carries out the two conditional short-branch instructions of a small 8-bit controller core whose instructions are 16 bits wide. Every instruction cycle is split into four fixed phases, and the block steps through them without pause. In the first phase it captures the instruction word. In the second it takes the signed byte offset from the low byte of that word. In the third it samples the Zero and Overflow flags and decides whether the branch is taken. In the fourth it updates the program counter.

A branch that is not taken, and any word that is not one of the two branch encodings, moves the program counter on by one word (2 bytes) with no write strobe. A taken branch loads the program counter with a target. The target is measured from the already-advanced counter and uses a doubled signed offset. A taken branch then spends one further instruction cycle idle, and during that cycle busy and flush stay high so that the word already prefetched is thrown away. The program counter is owned by this block, is 21 bits wide and is always even.

Top module: `cond_branch_seq`

## Requirements
- R1: While `rst_n` is low, and for the two clock edges after it rises, `phase` is 0, `pc` is 0, and `pc_wr`, `busy` and `flush` are 0.
- R2: `phase` counts 0,1,2,3 (for Q1..Q4) and then wraps to 0, one step per clock. The program counter changes only on the edge that ends phase 3.
- R3: A word whose upper byte is 8'hE1 (branch if not zero) is taken when `zero_flag` is 0. `ovf_flag` plays no part in the decision.
- R4: A word whose upper byte is 8'hE5 (branch if not overflow) is taken when `ovf_flag` is 0. `zero_flag` plays no part in the decision.
- R5: The taken target is pc + 2 + 2*n modulo 2^21, where n is the low byte of the word read as two's complement (-128..127). Bit 0 of the target is 0.
- R6: For a taken branch, `pc_wr` is 1 during phase 3 of that cycle and at no other time. During that phase `pc_next` shows the target, and `pc` takes that value on the edge that ends the phase.
- R7: A branch that is not taken, or a word with any other upper byte, gives no `pc_wr` and no `flush`. `pc` rises by 2 on the edge that ends phase 3.
- R8: After a taken branch, `busy` and `flush` are 1 for all four phases of the next instruction cycle. The instruction word and flags presented during that cycle are ignored: `pc_wr` stays 0 and `pc` is unchanged at the end of that cycle.
- R9: The instruction word is sampled on the edge that ends phase 0, and the flags on the edge that ends phase 2. Changes at other times do not affect the decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one phase per cycle |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| instr_word | input | 16 | Fetched instruction word |
| zero_flag | input | 1 | Zero status flag |
| ovf_flag | input | 1 | Overflow status flag |
| phase | output | 2 | Current phase, 0..3 for Q1..Q4 |
| pc | output | 21 | Program counter |
| pc_next | output | 21 | Value `pc` takes at the end of the current instruction cycle |
| pc_wr | output | 1 | Branch write strobe in phase 3 of a taken branch |
| flush | output | 1 | Discard the prefetched word |
| busy | output | 1 | Second cycle of a taken branch in progress |

## Verification
A wrong phase count, or a decode or flag-sample register updated in the wrong phase, shows at the ports within one instruction cycle (four clocks). It appears as a `pc_wr` in the wrong phase or in the wrong sense, or as a `pc` that does not move by exactly 2. A bad target adder shows as a wrong `pc_next` in phase 3 of the same cycle. Offsets of 0x80, 0x7F, 0x00 and 0xFF from a counter near zero expose both the sign extension and the wrap modulo 2^21. A busy flag that clears early, or that fails to block capture, shows within the following cycle as `flush` dropping too soon or as a spurious write from the word driven during the idle cycle.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

  typedef enum logic [1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } phase_e;

  typedef enum logic [1:0] {
    COND_NONE = 2'd0,
    COND_NZ   = 2'd1,
    COND_NOV  = 2'd2
  } cond_e;

  localparam int unsigned OPC_W = 8;
  localparam logic [OPC_W-1:0] OPC_BR_NZ  = 8'hE1;
  localparam logic [OPC_W-1:0] OPC_BR_NOV = 8'hE5;

endpackage

// File: rtl/bseq_rst_sync.sv
module bseq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bseq_phase.sv
module bseq_phase
  import bseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase
);
  phase_e ph_q;
  phase_e ph_d;

  always_comb begin
    unique case (ph_q)
      PH_Q1:   ph_d = PH_Q2;
      PH_Q2:   ph_d = PH_Q3;
      PH_Q3:   ph_d = PH_Q4;
      default: ph_d = PH_Q1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_Q1;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;

  // R2
  wrap_to_q1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_Q4) |=> (ph_q == PH_Q1));
endmodule

// File: rtl/bseq_decode.sv
module bseq_decode
  import bseq_pkg::*;
#(
  parameter int unsigned IW = 16
) (
  input  logic [IW-1:0] word,
  output cond_e         cond
);
  logic [OPC_W-1:0] opc;

  assign opc = word[IW-1 -: OPC_W];

  always_comb begin
    if (opc == OPC_BR_NZ)       cond = COND_NZ;
    else if (opc == OPC_BR_NOV) cond = COND_NOV;
    else                        cond = COND_NONE;
  end
endmodule

// File: rtl/bseq_target.sv
module bseq_target #(
  parameter int unsigned PC_W  = 21,
  parameter int unsigned OFS_W = 8
) (
  input  logic [PC_W-1:0]  pc_cur,
  input  logic [OFS_W-1:0] ofs,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  target
);
  localparam int unsigned EXT_W = PC_W - OFS_W - 1;

  logic [PC_W-1:0] step;
  logic [PC_W-1:0] disp;
  logic [PC_W-1:0] sum;

  assign step   = PC_W'(2);
  assign seq_pc = pc_cur + step;
  assign disp   = {{EXT_W{ofs[OFS_W-1]}}, ofs, 1'b0};
  assign sum    = seq_pc + disp;
  assign target = {sum[PC_W-1:1], 1'b0};
endmodule

// File: rtl/cond_branch_seq.sv
module cond_branch_seq
  import bseq_pkg::*;
#(
  parameter int unsigned PC_W  = 21,
  parameter int unsigned IW    = 16,
  parameter int unsigned OFS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   instr_word,
  input  logic            zero_flag,
  input  logic            ovf_flag,
  output logic [1:0]      phase,
  output logic [PC_W-1:0] pc,
  output logic [PC_W-1:0] pc_next,
  output logic            pc_wr,
  output logic            flush,
  output logic            busy
);
  logic rst_i_n;
  phase_e ph;
  cond_e  cond;

  logic [IW-1:0]    instr_q, instr_d;
  logic [OFS_W-1:0] ofs_q, ofs_d;
  logic             taken_q, taken_d;
  logic             busy_q, busy_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [PC_W-1:0]  seq_pc, target;

  logic cap_en, ofs_en, dec_en, end_en;

  bseq_rst_sync #(.STAGES(2)) i_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  bseq_phase i_phase (.clk(clk), .rst_n(rst_i_n), .phase(ph));

  bseq_decode #(.IW(IW)) i_dec (.word(instr_q), .cond(cond));

  bseq_target #(.PC_W(PC_W), .OFS_W(OFS_W)) i_tgt (
    .pc_cur(pc_q), .ofs(ofs_q), .seq_pc(seq_pc), .target(target));

  // clock enables, one per phase; capture is blocked during the idle cycle
  assign cap_en = (ph == PH_Q1) && !busy_q;
  assign ofs_en = (ph == PH_Q2) && !busy_q;
  assign dec_en = (ph == PH_Q3) && !busy_q;
  assign end_en = (ph == PH_Q4);

  always_comb begin
    instr_d = cap_en ? instr_word : instr_q;
    ofs_d   = ofs_en ? instr_q[OFS_W-1:0] : ofs_q;
    taken_d = taken_q;
    if (dec_en) begin
      unique case (cond)
        COND_NZ:  taken_d = !zero_flag;
        COND_NOV: taken_d = !ovf_flag;
        default:  taken_d = 1'b0;
      endcase
    end
    if (busy_q)       pc_next = pc_q;
    else if (taken_q) pc_next = target;
    else              pc_next = seq_pc;
    pc_d   = end_en ? pc_next : pc_q;
    busy_d = end_en ? (!busy_q && taken_q) : busy_q;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      instr_q <= '0;
      ofs_q   <= '0;
      taken_q <= 1'b0;
      busy_q  <= 1'b0;
      pc_q    <= '0;
    end else begin
      instr_q <= instr_d;
      ofs_q   <= ofs_d;
      taken_q <= taken_d;
      busy_q  <= busy_d;
      pc_q    <= pc_d;
    end
  end

  assign phase = ph;
  assign pc    = pc_q;
  assign pc_wr = end_en && !busy_q && taken_q;
  assign busy  = busy_q;
  assign flush = busy_q;

  // R6
  wr_phase_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    pc_wr |-> (phase == 2'd3) && !busy);

  // R8
  wr_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    pc_wr |=> busy && flush && (phase == 2'd0));

  // R8
  idle_keeps_pc_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (busy && phase == 2'd3) |=> !busy && $stable(pc));

  // R7
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (phase == 2'd3 && !busy && !pc_wr) |=> (pc == $past(pc) + PC_W'(2)));

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (phase != 2'd3) |=> $stable(pc));

  // R5
  pc_even_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    !pc[0] && !pc_next[0]);

  // R1
  always_comb begin
    if (!rst_n) rst_quiet_chk: assert (!pc_wr && !busy && !flush);
  end
endmodule

// File: tb/test_cond_branch_seq.sv
module test_cond_branch_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] instr_word;
  logic        zero_flag, ovf_flag;
  logic [1:0]  phase;
  logic [20:0] pc, pc_next;
  logic        pc_wr, flush, busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [20:0] mpc;

  always #5 clk = ~clk;

  cond_branch_seq i_cond_branch_seq (
    .clk(clk), .rst_n(rst_n), .instr_word(instr_word),
    .zero_flag(zero_flag), .ovf_flag(ovf_flag), .phase(phase),
    .pc(pc), .pc_next(pc_next), .pc_wr(pc_wr), .flush(flush), .busy(busy));

  // {word, zero, ovf, expected taken}
  localparam logic [18:0] VEC [16] = '{
    {16'hE180, 1'b0, 1'b1, 1'b1},  // R3 R5 -128 wraps below 0
    {16'hE105, 1'b1, 1'b0, 1'b0},  // R3 not taken
    {16'hE5FE, 1'b1, 1'b0, 1'b1},  // R4 offset -2
    {16'hE510, 1'b0, 1'b1, 1'b0},  // R4 not taken
    {16'hE17F, 1'b0, 1'b0, 1'b1},  // R5 +127
    {16'hE300, 1'b0, 1'b0, 1'b0},  // R7 unmatched
    {16'hE500, 1'b0, 1'b0, 1'b1},  // R5 zero offset still taken
    {16'h6105, 1'b0, 1'b0, 1'b0},  // R7 unmatched
    {16'hE1FF, 1'b1, 1'b1, 1'b0},  // R3 not taken
    {16'hE580, 1'b1, 1'b0, 1'b1},  // R4 -128
    {16'hE101, 1'b0, 1'b1, 1'b1},  // R3 ovf ignored
    {16'hE501, 1'b0, 1'b1, 1'b0},  // R4 zero ignored
    {16'hE1FF, 1'b0, 1'b1, 1'b1},  // R5 -1
    {16'hA5E1, 1'b0, 1'b0, 1'b0},  // R7 opcode in low byte
    {16'hE5C0, 1'b0, 1'b0, 1'b1},  // R4 R5 -64
    {16'hE6FF, 1'b1, 1'b1, 1'b0}   // R7 unmatched
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [20:0] tgt(input logic [20:0] p, input logic [7:0] n);
    logic [20:0] d;
    d = {{12{n[7]}}, n, 1'b0};
    return (p + 21'd2 + d) & 21'h1FFFFE;
  endfunction

  // Entered at a negedge with the next edge ending phase 0; left the same way.
  task automatic run_instr(input logic [15:0] w, input logic z, input logic v,
                           input logic exp_t);
    logic [20:0] e;
    instr_word = w; zero_flag = z; ovf_flag = v;
    e = exp_t ? tgt(mpc, w[7:0]) : mpc + 21'd2;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(phase == 2'd3, "R2", "phase in Q4", phase, 3);
    chk(pc_wr == exp_t, exp_t ? "R6" : "R7", "pc_wr", pc_wr, exp_t);
    chk(pc_next == e, "R5", "pc_next", pc_next, e);
    @(posedge clk); @(negedge clk);
    mpc = e;
    chk(pc == mpc, "R6", "pc after Q4", pc, mpc);
    chk(flush == exp_t && busy == exp_t, "R8", "flush/busy", {busy, flush}, {exp_t, exp_t});
    if (exp_t) begin
      instr_word = 16'hE100; zero_flag = 1'b0; ovf_flag = 1'b0;  // ignored
      for (int k = 1; k < 4; k++) begin
        @(posedge clk); @(negedge clk);
        chk(flush && busy && !pc_wr, "R8", "idle phase", {busy, flush, pc_wr}, 3'b110);
      end
      @(posedge clk); @(negedge clk);
      chk(!busy && !flush && pc == mpc, "R8", "after idle", pc, mpc);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    chk(phase == 0 && pc == 0 && !pc_wr && !busy && !flush, "R1", "in reset",
        {phase, pc, pc_wr, busy, flush}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    chk(phase == 0 && pc == 0 && !busy && !flush, "R1", "after release",
        {phase, pc, busy, flush}, 0);
    mpc = '0;
  endtask

  initial begin
    rst_n = 1'b0; instr_word = '0; zero_flag = 1'b0; ovf_flag = 1'b0;
    mpc = '0;
    do_reset();

    for (int i = 0; i < 16; i++)
      run_instr(VEC[i][18:3], VEC[i][2], VEC[i][1], VEC[i][0]);

    // R9: word changes after phase 0 and flags valid only at the end of phase 2
    begin
      logic [20:0] e;
      instr_word = 16'hE110; zero_flag = 1'b1; ovf_flag = 1'b0;
      e = tgt(mpc, 8'h10);
      @(posedge clk); @(negedge clk);
      instr_word = 16'h0000;
      @(posedge clk); @(negedge clk);
      zero_flag = 1'b0;
      @(posedge clk); @(negedge clk);
      zero_flag = 1'b1;
      chk(pc_wr && pc_next == e, "R9", "late-sampled taken", pc_next, e);
      @(posedge clk); @(negedge clk);
      mpc = e;
      chk(pc == mpc, "R9", "pc target", pc, mpc);
      repeat (4) @(posedge clk);
      @(negedge clk);
    end

    // R9: flags true in phase 0/1 but false at end of phase 2 -> not taken
    begin
      instr_word = 16'hE520; ovf_flag = 1'b0;
      @(posedge clk); @(negedge clk);
      @(posedge clk); @(negedge clk);
      ovf_flag = 1'b1;
      @(posedge clk); @(negedge clk);
      ovf_flag = 1'b0;
      chk(!pc_wr, "R9", "flag at Q3 edge", pc_wr, 0);
      @(posedge clk); @(negedge clk);
      mpc = mpc + 21'd2;
      chk(pc == mpc && !flush, "R7", "sequential", pc, mpc);
    end

    // R1: reset in the middle of a taken branch
    instr_word = 16'hE140; zero_flag = 1'b0;
    repeat (2) @(posedge clk);
    do_reset();
    run_instr(16'hE103, 1'b0, 1'b0, 1'b1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule